// File: doc/BRIEF.md
# Privilege Mode Trap Redirect Unit

This unit keeps track of the privilege level of one hardware thread. It works out where execution continues when a trap is taken or when a return-from-trap instruction retires. When a trap arrives, the unit picks the level that handles it, either machine or supervisor. It computes that level's handler address, which is either a direct or a vectored target. It saves the faulting program counter and the interrupted mode into that level's registers. When a machine-return or supervisor-return pulse arrives, the unit restores the mode and program counter from the saved state of the matching level.

The vector bases arrive as inputs from the surrounding control-register file. The low two bits of each base select how the target is formed. The unit drives three outputs, all registered: a one-cycle redirect strobe, the new program counter and the current mode. Each updates on the clock edge that samples the request.

Top module: `priv_trap_redirect`

## Requirements
- R1: The first cycle after a synchronous reset shows `cur_mode` = 2'b11 (machine), `redir_valid` = 0 and `redir_pc` = 0. Reset also clears both saved program counters and both previous-mode fields to user.
- R2: Modes are encoded as user = 2'b00, supervisor = 2'b01 and machine = 2'b11. `cur_mode` never shows 2'b10.
- R3: A trap goes to supervisor (2'b01) only when `trap_deleg` is 1 and the current mode is not machine. In every other case it goes to machine (2'b11). A trap never leaves the thread at a lower level than it held before the trap.
- R4: A trap target is the handling level's vector base with bits [1:0] cleared. Base bits [1:0] = 2'b01 select vectored mode. Any other value selects direct mode.
- R5: In vectored mode an interrupt (`trap_irq` = 1) redirects to the cleared base plus 4 × `trap_cause`.
- R6: A synchronous exception (`trap_irq` = 0) always redirects to the cleared base, even in vectored mode.
- R7: On a trap, `trap_pc` is stored as the handling level's exception PC, and the mode before the trap is stored as that level's previous mode. The supervisor's previous mode is 1 bit: 0 = user, 1 = supervisor.
- R8: A machine return sets the mode to the saved machine previous mode and `redir_pc` to the machine exception PC. It then resets the machine previous mode to user.
- R9: A supervisor return sets the mode to supervisor when its saved bit is 1 and to user when it is 0. It sets `redir_pc` to the supervisor exception PC and then clears the saved bit to user.
- R10: A trap takes priority over any return pulse in the same cycle. When both return pulses arrive without a trap, the machine return takes priority.
- R11: `redir_valid` is high for exactly one cycle, the cycle after a trap or return is sampled. With no request, `redir_valid` is 0 and `redir_pc` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request, sampled each cycle |
| trap_irq | input | 1 | 1 = interrupt, 0 = synchronous exception |
| trap_cause | input | CAUSE_W | Cause number, used for the vectored offset |
| trap_deleg | input | 1 | Trap is delegated toward the supervisor level |
| trap_pc | input | XLEN | Program counter of the trapping instruction |
| mret_req | input | 1 | Machine-return retire pulse |
| sret_req | input | 1 | Supervisor-return retire pulse |
| m_vec_base | input | XLEN | Machine handler base; bits [1:0] select the mode |
| s_vec_base | input | XLEN | Supervisor handler base; bits [1:0] select the mode |
| redir_valid | output | 1 | One-cycle strobe: fetch must restart at `redir_pc` |
| redir_pc | output | XLEN | Redirect target |
| cur_mode | output | 2 | Current privilege mode |

## Verification
The assertions assume that the vector bases stay stable while they are sampled with a trap. They also assume that the return pulses are legal in the current mode, so that a machine return is issued only from machine mode. The stimulus follows these rules: it changes the bases only together with the trap that uses them, and it issues each return only after a trap has placed the thread at a level that allows that return. One deliberate exception tests the priority rules: a return is driven together with a trap, and both returns are driven together.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] MODE_U = 2'b00;
  localparam logic [1:0] MODE_S = 2'b01;
  localparam logic [1:0] MODE_M = 2'b11;
  localparam logic [1:0] VEC_VECTORED = 2'b01;
endpackage

// File: rtl/trap_target_calc.sv
module trap_target_calc #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic [XLEN-1:0]    vec_base,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    target
);
  import trap_pkg::*;
  localparam int OFS_HI = CAUSE_W + 1;

  logic [XLEN-1:0] base_al;
  logic [XLEN-1:0] ofs;

  always_comb begin
    base_al = {vec_base[XLEN-1:2], 2'b00};
    ofs = '0;
    ofs[OFS_HI:2] = cause;
    // only interrupts in vectored mode take an offset
    if (is_irq && vec_base[1:0] == VEC_VECTORED) target = base_al + ofs;
    else target = base_al;
  end
endmodule

// File: rtl/trap_state.sv
module trap_state #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_trap,
  input  logic            to_super,
  input  logic [XLEN-1:0] fault_pc,
  input  logic            do_mret,
  input  logic            do_sret,
  output logic [1:0]      mode_q,
  output logic [XLEN-1:0] m_epc_q,
  output logic [XLEN-1:0] s_epc_q,
  output logic [1:0]      m_prev_q,
  output logic            s_prev_q
);
  import trap_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_M;
      m_epc_q  <= '0;
      s_epc_q  <= '0;
      m_prev_q <= MODE_U;
      s_prev_q <= 1'b0;
    end else if (take_trap) begin
      if (to_super) begin
        s_epc_q  <= fault_pc;
        s_prev_q <= (mode_q == MODE_S);
        mode_q   <= MODE_S;
      end else begin
        m_epc_q  <= fault_pc;
        m_prev_q <= mode_q;
        mode_q   <= MODE_M;
      end
    end else if (do_mret) begin
      mode_q   <= m_prev_q;
      m_prev_q <= MODE_U;
    end else if (do_sret) begin
      mode_q   <= s_prev_q ? MODE_S : MODE_U;
      s_prev_q <= 1'b0;
    end
  end
endmodule

// File: rtl/priv_trap_redirect.sv
module priv_trap_redirect #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_req,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               trap_deleg,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               mret_req,
  input  logic               sret_req,
  input  logic [XLEN-1:0]    m_vec_base,
  input  logic [XLEN-1:0]    s_vec_base,
  output logic               redir_valid,
  output logic [XLEN-1:0]    redir_pc,
  output logic [1:0]         cur_mode
);
  import trap_pkg::*;
  localparam int NLVL = 2;

  logic [XLEN-1:0] bases [NLVL];
  logic [XLEN-1:0] tgts  [NLVL];
  logic [1:0]      mode_q;
  logic [XLEN-1:0] m_epc_q, s_epc_q;
  logic [1:0]      m_prev_q;
  logic            s_prev_q;
  logic            to_super, do_mret, do_sret;

  assign bases[0] = m_vec_base;
  assign bases[1] = s_vec_base;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    trap_target_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_calc (
      .vec_base(bases[g]),
      .is_irq  (trap_irq),
      .cause   (trap_cause),
      .target  (tgts[g])
    );
  end

  assign to_super = trap_deleg && (mode_q != MODE_M);
  assign do_mret  = !trap_req && mret_req;
  assign do_sret  = !trap_req && !mret_req && sret_req;

  trap_state #(.XLEN(XLEN)) u_state (
    .clk      (clk),
    .rst      (rst),
    .take_trap(trap_req),
    .to_super (to_super),
    .fault_pc (trap_pc),
    .do_mret  (do_mret),
    .do_sret  (do_sret),
    .mode_q   (mode_q),
    .m_epc_q  (m_epc_q),
    .s_epc_q  (s_epc_q),
    .m_prev_q (m_prev_q),
    .s_prev_q (s_prev_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
    end else begin
      redir_valid <= trap_req || do_mret || do_sret;
      if (trap_req)     redir_pc <= to_super ? tgts[1] : tgts[0];
      else if (do_mret) redir_pc <= m_epc_q;
      else if (do_sret) redir_pc <= s_epc_q;
    end
  end

  assign cur_mode = mode_q;
endmodule

// File: rtl/trap_redirect_chk.sv
module trap_redirect_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               trap_req,
  input logic               trap_irq,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic               trap_deleg,
  input logic [XLEN-1:0]    m_vec_base,
  input logic               mret_req,
  input logic               sret_req,
  input logic               redir_valid,
  input logic [XLEN-1:0]    redir_pc,
  input logic [1:0]         cur_mode
);
  // R1
  reset_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_mode == 2'b11 && !redir_valid));

  // R2
  legal_mode_chk: assert property (@(posedge clk) disable iff (rst)
    cur_mode != 2'b10);

  // R3
  trap_raise_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> cur_mode >= $past(cur_mode));

  // R3
  undeleg_m_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !trap_deleg) |=> cur_mode == 2'b11);

  // R6
  exc_base_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !trap_irq && !trap_deleg) |=>
      redir_pc == {$past(m_vec_base[XLEN-1:2]), 2'b00});

  // R5
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req && trap_irq && !trap_deleg && m_vec_base[1:0] == 2'b01) |=>
      redir_pc == $past({m_vec_base[XLEN-1:2], 2'b00} + (XLEN'(trap_cause) << 2)));

  // R11
  strobe_on_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_req || mret_req || sret_req) |=> redir_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && !mret_req && !sret_req) |=> (!redir_valid && $stable(redir_pc)));
endmodule

bind priv_trap_redirect trap_redirect_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .trap_req   (trap_req),
  .trap_irq   (trap_irq),
  .trap_cause (trap_cause),
  .trap_deleg (trap_deleg),
  .m_vec_base (m_vec_base),
  .mret_req   (mret_req),
  .sret_req   (sret_req),
  .redir_valid(redir_valid),
  .redir_pc   (redir_pc),
  .cur_mode   (cur_mode)
);

// File: tb/sim_priv_trap_redirect.sv
module sim_priv_trap_redirect;
  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam int NV   = 16;

  typedef struct packed {
    logic [1:0]      op;     // 0 trap, 1 mret, 2 sret, 3 trap with mret
    logic            irq;
    logic            dlg;
    logic [CW-1:0]   cause;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] mvec;
    logic [XLEN-1:0] svec;
    logic [XLEN-1:0] exp_pc;
    logic [1:0]      exp_mode;
    logic [7:0]      req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b1, 5'd2, 32'h40, 32'h1001, 32'h2000, 32'h1000, 2'b11, 8'd3},
    '{2'd1, 1'b0, 1'b0, 5'd0, 32'h0,  32'h1001, 32'h2000, 32'h40,   2'b11, 8'd8},
    '{2'd1, 1'b0, 1'b0, 5'd0, 32'h0,  32'h1001, 32'h2000, 32'h40,   2'b00, 8'd8},
    '{2'd0, 1'b1, 1'b0, 5'd5, 32'h80, 32'h1001, 32'h2000, 32'h1014, 2'b11, 8'd5},
    '{2'd1, 1'b0, 1'b0, 5'd0, 32'h0,  32'h1001, 32'h2000, 32'h80,   2'b00, 8'd8},
    '{2'd0, 1'b0, 1'b1, 5'd8, 32'h90, 32'h1001, 32'h2000, 32'h2000, 2'b01, 8'd3},
    '{2'd0, 1'b1, 1'b1, 5'd1, 32'hA0, 32'h1001, 32'h2001, 32'h2004, 2'b01, 8'd5},
    '{2'd2, 1'b0, 1'b0, 5'd0, 32'h0,  32'h1001, 32'h2001, 32'hA0,   2'b01, 8'd9},
    '{2'd0, 1'b0, 1'b1, 5'd3, 32'hB0, 32'h1001, 32'h2001, 32'h2000, 2'b01, 8'd6},
    '{2'd2, 1'b0, 1'b0, 5'd0, 32'h0,  32'h1001, 32'h2001, 32'hB0,   2'b01, 8'd9},
    '{2'd2, 1'b0, 1'b0, 5'd0, 32'h0,  32'h1001, 32'h2001, 32'hB0,   2'b00, 8'd9},
    '{2'd0, 1'b1, 1'b1, 5'd7, 32'hC0, 32'h1001, 32'h2000, 32'h2000, 2'b01, 8'd4},
    '{2'd0, 1'b0, 1'b0, 5'd2, 32'hD0, 32'h1001, 32'h2000, 32'h1000, 2'b11, 8'd6},
    '{2'd1, 1'b0, 1'b0, 5'd0, 32'h0,  32'h1001, 32'h2000, 32'hD0,   2'b01, 8'd7},
    '{2'd3, 1'b1, 1'b0, 5'd3, 32'hE0, 32'h1001, 32'h2000, 32'h100C, 2'b11, 8'd10},
    '{2'd1, 1'b0, 1'b0, 5'd0, 32'h0,  32'h1001, 32'h2000, 32'hE0,   2'b01, 8'd8}
  };

  logic            clk = 1'b0;
  logic            rst;
  logic            trap_req, trap_irq, trap_deleg, mret_req, sret_req;
  logic [CW-1:0]   trap_cause;
  logic [XLEN-1:0] trap_pc, m_vec_base, s_vec_base;
  logic            redir_valid;
  logic [XLEN-1:0] redir_pc;
  logic [1:0]      cur_mode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  priv_trap_redirect #(.XLEN(XLEN), .CAUSE_W(CW)) u0 (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .trap_deleg(trap_deleg), .trap_pc(trap_pc),
    .mret_req(mret_req), .sret_req(sret_req), .m_vec_base(m_vec_base),
    .s_vec_base(s_vec_base), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .cur_mode(cur_mode)
  );

  task automatic chk(input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    trap_req = 0; trap_irq = 0; trap_deleg = 0; trap_cause = '0;
    trap_pc = '0; mret_req = 0; sret_req = 0;
  endtask

  // the redirect is registered, so outputs are sampled one negedge after driving
  task automatic run_vec(input vec_t v, input int idx);
    logic [XLEN-1:0] held;
    string tag;
    @(negedge clk);
    trap_req   = (v.op == 2'd0 || v.op == 2'd3);
    mret_req   = (v.op == 2'd1 || v.op == 2'd3);
    sret_req   = (v.op == 2'd2);
    trap_irq   = v.irq;
    trap_deleg = v.dlg;
    trap_cause = v.cause;
    trap_pc    = v.pc;
    m_vec_base = v.mvec;
    s_vec_base = v.svec;
    @(negedge clk);
    idle();
    tag = $sformatf("R%0d vec%0d", v.req, idx);
    chk({tag, " pc"}, redir_pc, v.exp_pc);
    chk({tag, " mode"}, XLEN'(cur_mode), XLEN'(v.exp_mode));
    chk("R11 strobe", XLEN'(redir_valid), 1);
    held = redir_pc;
    @(negedge clk);
    chk("R11 pulse end", XLEN'(redir_valid), 0);
    chk("R11 pc held", redir_pc, held);
    chk("R2 legal mode", XLEN'(cur_mode != 2'b10), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    idle();
    m_vec_base = 32'h1001;
    s_vec_base = 32'h2000;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 mode", XLEN'(cur_mode), 32'h3);
    chk("R1 valid", XLEN'(redir_valid), 0);
    chk("R1 pc", redir_pc, 0);

    // R3 R4 R5 R6 R7 R8 R9 R10 walked through the table
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10: both returns at once from supervisor, machine return wins (saved mode user, pc 0xE0)
    @(negedge clk);
    mret_req = 1; sret_req = 1;
    @(negedge clk);
    idle();
    chk("R10 dual return pc", redir_pc, 32'hE0);
    chk("R10 dual return mode", XLEN'(cur_mode), 0);

    // R1 reset in mid-run
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 rerun mode", XLEN'(cur_mode), 32'h3);
    chk("R1 rerun valid", XLEN'(redir_valid), 0);
    chk("R1 rerun pc", redir_pc, 0);

    // R8 after reset: saved mode is user and the saved pc is 0
    @(negedge clk);
    mret_req = 1;
    @(negedge clk);
    idle();
    chk("R8 post-reset mode", XLEN'(cur_mode), 0);
    chk("R8 post-reset pc", redir_pc, 0);

    // R4: base bits 2'b11 count as direct, so an interrupt gets no offset
    @(negedge clk);
    m_vec_base = 32'h3003;
    trap_req = 1; trap_irq = 1; trap_cause = 5'd9; trap_pc = 32'h44;
    @(negedge clk);
    idle();
    chk("R4 mode bits 11 direct", redir_pc, 32'h3000);
    chk("R3 user to machine", XLEN'(cur_mode), 32'h3);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule